// File: doc/BRIEF.md
# Dual-Channel Match Timer

This peripheral holds two 16-bit counter channels and a shared bank of six compare registers. Each channel has a loadable count, a prescale divider and a control word. The control word starts or halts the channel, sets whether it counts up or down, and either ties the channel to one compare register or lets it run freely. When a channel that is tied to a compare register steps onto that register's value, it stops advancing. At the same moment it raises a sticky status bit that belongs to that compare register.

A second register window holds the six status bits and a six-bit enable mask. Any status bit that is set and enabled drives the single interrupt line, one clock later. Software clears status bits by writing ones to the status word. A typical sequence loads a countdown delta, arms the channel with compare register 0 held at zero, waits for the interrupt, and then acknowledges it. The other channel can run freely as an up-counting time base.

Access uses one synchronous port. A region select picks the timer window or the interrupt window, and a word index picks the register inside it. Read data appears one clock after the index is presented.

Top module: `dual_match_timer`

## Requirements
- R1: After reset, every count, divider and compare register reads 0, each control word reads 0x10 (halted, down, no target), the status and mask words read 0, and irq is low.
- R2: In the timer window, channel c holds count, divider and control at word indices 3c, 3c+1 and 3c+2. Compare register n sits at word index 6+n. In the interrupt window, status is at word 0 and mask is at word 1. Reads return the addressed register one clock later, and an unmapped index reads 0.
- R3: While control bit 4 is 1 the channel count does not change, except by a direct write.
- R4: Control bit 3 = 1 counts up and 0 counts down. Both directions wrap modulo 2^16 (0xFFFF to 0x0000 going up, 0x0000 to 0xFFFF going down).
- R5: With divider value D, a running channel advances once every D+1 clocks. Writing the count or the divider restarts this phase, so the first advance comes D+1 clocks after the write.
- R6: A control field [2:0] of n+1 (n = 0..5) ties the channel to compare register n, and the channel stops advancing while its count equals that register. The values 0 and 7 run freely with no target.
- R7: Status bit n becomes 1 in the same clock edge on which a channel tied to compare register n advances onto that register's value. It then stays 1.
- R8: Writing to status clears each bit written as 1. A bit that is being set by a match in the same cycle stays 1.
- R9: irq equals the OR over the six bits of (status AND mask), registered once.
- R10: A write to a count loads the written value. It takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_irq_win | input | 1 | 0 selects the timer window, 1 selects the interrupt window |
| bus_addr | input | 4 | Word index inside the selected window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest collision is an acknowledge write to the status word landing on the same edge as a counter stepping onto its compare value. The bench arms a countdown from 3 with a divider of 0. It schedules a write of 0x3F to status on exactly the third edge after the arming write, while another status bit is already pending. The expected status afterwards is 0x01: the old bit is cleared and the new match survives. A second overlap, a count write on an edge where the channel also advances, is judged by reading back the loaded value plus exactly one following step.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTL_W = 5;
  localparam int SEL_W = 3;

  typedef struct packed {
    logic             stop;
    logic             up;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{stop: 1'b1, up: 1'b0, sel: '0};
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we_cnt,
  input  logic                     we_div,
  input  logic                     we_ctl,
  input  logic [CNT_W-1:0]         wdata,
  input  logic [N_MATCH*CNT_W-1:0] match_flat,
  output logic [CNT_W-1:0]         cnt_o,
  output logic [CNT_W-1:0]         div_o,
  output ctl_t                     ctl_o,
  output logic [N_MATCH-1:0]       evt_o
);
  logic [CNT_W-1:0] cnt_q, div_q, phase_q, cnt_nxt, tgt;
  ctl_t             ctl_q;
  logic             run, has_tgt, at_tgt, tick, adv;

  always_comb begin
    run     = !ctl_q.stop;
    has_tgt = 1'b0;
    tgt     = '0;
    for (int m = 0; m < N_MATCH; m++) begin
      if (ctl_q.sel == SEL_W'(m + 1)) begin
        has_tgt = 1'b1;
        tgt     = match_flat[m*CNT_W +: CNT_W];
      end
    end
    at_tgt  = has_tgt && (cnt_q == tgt);
    tick    = run && (phase_q == div_q);
    adv     = tick && !at_tgt;
    cnt_nxt = ctl_q.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    for (int m = 0; m < N_MATCH; m++) begin
      evt_o[m] = adv && (ctl_q.sel == SEL_W'(m + 1)) && (cnt_nxt == tgt);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      div_q   <= '0;
      phase_q <= '0;
      ctl_q   <= CTL_RESET;
    end else begin
      if (run) phase_q <= tick ? '0 : phase_q + 1'b1;
      if (adv) cnt_q <= cnt_nxt;
      if (we_cnt) begin
        cnt_q   <= wdata;
        phase_q <= '0;
      end
      if (we_div) begin
        div_q   <= wdata;
        phase_q <= '0;
      end
      if (we_ctl) ctl_q <= ctl_t'(wdata[CTL_W-1:0]);
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
  assign ctl_o = ctl_q;

  // R3: a halted channel keeps its count unless software loads it
  a_r3_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.stop && !we_cnt) |=> $stable(cnt_q));
  // R6: a channel sitting on its target does not move
  a_r6_target_holds: assert property (@(posedge clk) disable iff (rst)
    (at_tgt && !we_cnt) |=> $stable(cnt_q));
  // R7: one channel flags at most one compare register per cycle
  a_r7_evt_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt_o));
  // R5: the prescale phase never runs past the divider
  a_r5_phase_bound: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase_q <= div_q));
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int N_MATCH = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_MATCH-1:0] evt_i,
  input  logic               ack_we,
  input  logic               mask_we,
  input  logic [N_MATCH-1:0] wdata,
  output logic [N_MATCH-1:0] status_o,
  output logic [N_MATCH-1:0] mask_o,
  output logic               irq_o
);
  logic [N_MATCH-1:0] status_q, mask_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (ack_we ? (status_q & ~wdata) : status_q) | evt_i;
      if (mask_we) mask_q <= wdata;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  // R7: a match event always leaves its status bit set
  a_r7_evt_sets: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i)));
  // R8: without an acknowledge no status bit falls
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !ack_we |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R9: nothing enabled and pending means no request next cycle
  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((status_q & mask_q) == '0) |=> !irq_o);
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int N_CHAN  = 2,
  parameter int N_MATCH = 6,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_irq_win,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);
  localparam int REGS_PER_CH = 3;
  localparam int MATCH_BASE  = REGS_PER_CH * N_CHAN;

  logic [CNT_W-1:0]         match_q [N_MATCH];
  logic [N_MATCH*CNT_W-1:0] match_flat;
  logic [CNT_W-1:0]         ch_cnt [N_CHAN];
  logic [CNT_W-1:0]         ch_div [N_CHAN];
  ctl_t                     ch_ctl [N_CHAN];
  logic [N_MATCH-1:0]       ch_evt [N_CHAN];
  logic [N_MATCH-1:0]       evt_all, status, mask;
  logic [CNT_W-1:0]         rd_nxt, rd_q;
  logic                     tmr_we, ack_we, mask_we;

  assign tmr_we  = bus_we && !bus_irq_win;
  assign ack_we  = bus_we && bus_irq_win && (bus_addr == ADDR_W'(0));
  assign mask_we = bus_we && bus_irq_win && (bus_addr == ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int m = 0; m < N_MATCH; m++) match_q[m] <= '0;
    end else if (tmr_we) begin
      for (int m = 0; m < N_MATCH; m++)
        if (bus_addr == ADDR_W'(MATCH_BASE + m)) match_q[m] <= bus_wdata;
    end
  end

  always_comb begin
    for (int m = 0; m < N_MATCH; m++) match_flat[m*CNT_W +: CNT_W] = match_q[m];
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .we_cnt    (tmr_we && (bus_addr == ADDR_W'(REGS_PER_CH*c))),
      .we_div    (tmr_we && (bus_addr == ADDR_W'(REGS_PER_CH*c + 1))),
      .we_ctl    (tmr_we && (bus_addr == ADDR_W'(REGS_PER_CH*c + 2))),
      .wdata     (bus_wdata),
      .match_flat(match_flat),
      .cnt_o     (ch_cnt[c]),
      .div_o     (ch_div[c]),
      .ctl_o     (ch_ctl[c]),
      .evt_o     (ch_evt[c])
    );
  end

  always_comb begin
    evt_all = '0;
    for (int c = 0; c < N_CHAN; c++) evt_all = evt_all | ch_evt[c];
  end

  tmr_irq_ctrl #(.N_MATCH(N_MATCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt_all),
    .ack_we  (ack_we),
    .mask_we (mask_we),
    .wdata   (bus_wdata[N_MATCH-1:0]),
    .status_o(status),
    .mask_o  (mask),
    .irq_o   (irq)
  );

  always_comb begin
    rd_nxt = '0;
    if (bus_irq_win) begin
      if (bus_addr == ADDR_W'(0)) rd_nxt = {{(CNT_W-N_MATCH){1'b0}}, status};
      if (bus_addr == ADDR_W'(1)) rd_nxt = {{(CNT_W-N_MATCH){1'b0}}, mask};
    end else begin
      for (int c = 0; c < N_CHAN; c++) begin
        if (bus_addr == ADDR_W'(REGS_PER_CH*c))     rd_nxt = ch_cnt[c];
        if (bus_addr == ADDR_W'(REGS_PER_CH*c + 1)) rd_nxt = ch_div[c];
        if (bus_addr == ADDR_W'(REGS_PER_CH*c + 2))
          rd_nxt = {{(CNT_W-CTL_W){1'b0}}, ch_ctl[c]};
      end
      for (int m = 0; m < N_MATCH; m++)
        if (bus_addr == ADDR_W'(MATCH_BASE + m)) rd_nxt = match_q[m];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end

  assign bus_rdata = rd_q;

  // R1: reset leaves the request line low
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!irq && bus_rdata == '0));
endmodule

// File: tb/sim_dual_match_timer.sv
module sim_dual_match_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic        bus_irq_win = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  dual_match_timer u0 (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_irq_win(bus_irq_win),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  logic [15:0] m_cnt [2];
  logic [15:0] m_div [2];
  logic [15:0] m_ph  [2];
  logic [4:0]  m_ctl [2];
  logic [15:0] m_match [6];
  logic [5:0]  m_stat, m_mask, m_ev;
  logic        m_irq;
  logic [15:0] m_rd, t_nxt, t_tgt;
  int          t_sel, t_w;
  bit          t_tick, t_has;

  function automatic logic [15:0] m_read(bit win, int w);
    if (win) return (w == 0) ? {10'd0, m_stat} : (w == 1) ? {10'd0, m_mask} : 16'd0;
    if (w < 6) begin
      case (w % 3)
        0: return m_cnt[w/3];
        1: return m_div[w/3];
        default: return {11'd0, m_ctl[w/3]};
      endcase
    end
    if (w < 12) return m_match[w-6];
    return 16'd0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_div[i] = 0; m_ph[i] = 0; m_ctl[i] = 5'h10;
      end
      for (int i = 0; i < 6; i++) m_match[i] = 0;
      m_stat = 0; m_mask = 0; m_irq = 0; m_rd = 0;
    end else begin
      t_w  = int'(bus_addr);
      m_rd = m_read(bus_irq_win, t_w);
      m_irq = |(m_stat & m_mask);
      m_ev = 0;
      for (int c = 0; c < 2; c++) begin
        t_sel  = int'(m_ctl[c][2:0]);
        t_has  = (t_sel >= 1 && t_sel <= 6);
        t_tgt  = t_has ? m_match[t_sel-1] : 16'd0;
        t_tick = 0;
        if (!m_ctl[c][4]) begin
          if (m_ph[c] == m_div[c]) begin t_tick = 1; m_ph[c] = 0; end
          else m_ph[c] = m_ph[c] + 1;
        end
        if (t_tick && !(t_has && m_cnt[c] == t_tgt)) begin
          t_nxt = m_ctl[c][3] ? m_cnt[c] + 16'd1 : m_cnt[c] - 16'd1;
          if (t_has && t_nxt == t_tgt) m_ev[t_sel-1] = 1'b1;
          m_cnt[c] = t_nxt;
        end
        if (bus_we && !bus_irq_win) begin
          if (t_w == 3*c)     begin m_cnt[c] = bus_wdata; m_ph[c] = 0; end
          if (t_w == 3*c + 1) begin m_div[c] = bus_wdata; m_ph[c] = 0; end
          if (t_w == 3*c + 2) m_ctl[c] = bus_wdata[4:0];
        end
      end
      if (bus_we && !bus_irq_win && t_w >= 6 && t_w < 12) m_match[t_w-6] = bus_wdata;
      if (bus_we && bus_irq_win && t_w == 0) m_stat = m_stat & ~bus_wdata[5:0];
      m_stat = m_stat | m_ev;
      if (bus_we && bus_irq_win && t_w == 1) m_mask = bus_wdata[5:0];
    end
  end

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (cyc > 0 && !done) begin
      n_chk++;
      if (bus_rdata !== m_rd) begin
        n_err++;
        $display("FAIL R2 rdata cycle %0d act=%h exp=%h", cyc, bus_rdata, m_rd);
      end
      n_chk++;
      if (irq !== m_irq) begin
        n_err++;
        $display("FAIL R9 irq cycle %0d act=%b exp=%b", cyc, irq, m_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit win, input int a, input logic [15:0] d);
    bus_we = 1; bus_irq_win = win; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input bit win, input int a, output logic [15:0] v);
    bus_we = 0; bus_irq_win = win; bus_addr = 4'(a);
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    rd(0, 2, v);  chk("R1 ch0 control", v, 16'h0010);
    rd(0, 3, v);  chk("R1 ch1 count", v, 16'h0000);
    rd(0, 11, v); chk("R1 match5", v, 16'h0000);
    rd(1, 0, v);  chk("R1 status", v, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);
    // R2 map and readback
    wr(0, 11, 16'hABCD);
    rd(0, 11, v); chk("R2 match5 readback", v, 16'hABCD);
    rd(0, 12, v); chk("R2 unmapped", v, 16'h0000);
    wr(1, 1, 16'h002A);
    rd(1, 1, v);  chk("R2 mask readback", v, 16'h002A);
    wr(1, 1, 16'h0001);
    // R6/R7 countdown onto compare 0 (value 0)
    wr(0, 0, 16'd5);
    wr(0, 2, 16'h0001);
    repeat (10) @(negedge clk);
    rd(0, 0, v);  chk("R6 countdown holds at target", v, 16'h0000);
    rd(1, 0, v);  chk("R7 status bit0", v, 16'h0001);
    chk("R9 irq raised", {15'd0, irq}, 16'h0001);
    // R8 acknowledge
    wr(1, 0, 16'h0001);
    @(negedge clk);
    rd(1, 0, v);  chk("R8 status cleared", v, 16'h0000);
    chk("R9 irq dropped", {15'd0, irq}, 16'h0000);
    // R4/R6 up-count onto compare 2 with divider 1
    wr(0, 8, 16'h0010);
    wr(0, 3, 16'h000C);
    wr(0, 4, 16'h0001);
    wr(0, 5, 16'h000B);
    repeat (20) @(negedge clk);
    rd(0, 3, v);  chk("R4 up-count reached target", v, 16'h0010);
    rd(1, 0, v);  chk("R7 status bit2", v, 16'h0004);
    chk("R9 masked bit gives no irq", {15'd0, irq}, 16'h0000);
    // R8 collision: acknowledge on the match edge
    wr(0, 2, 16'h0010);
    wr(0, 0, 16'd3);
    wr(0, 2, 16'h0001);
    repeat (2) @(negedge clk);
    wr(1, 0, 16'h003F);
    rd(1, 0, v);  chk("R8 set wins over clear", v, 16'h0001);
    // R3 halted channel with loaded value
    wr(0, 2, 16'h0010);
    wr(0, 0, 16'd7);
    repeat (5) @(negedge clk);
    rd(0, 0, v);  chk("R3 halted count stable", v, 16'h0007);
    // R4 down wrap, free-running
    wr(0, 0, 16'h0001);
    wr(0, 2, 16'h0007);
    repeat (3) @(negedge clk);
    wr(0, 2, 16'h0017);
    rd(0, 0, v);  chk("R4 down wrap", v, 16'hFFFD);
    // R4 up wrap, free-running
    wr(0, 5, 16'h0018);
    wr(0, 4, 16'h0000);
    wr(0, 3, 16'hFFFE);
    wr(0, 5, 16'h000F);
    repeat (3) @(negedge clk);
    wr(0, 5, 16'h001F);
    rd(0, 3, v);  chk("R4 up wrap", v, 16'h0002);
    // R5 prescaler: divider 2 advances every third clock
    wr(0, 0, 16'h0000);
    wr(0, 1, 16'h0002);
    wr(0, 2, 16'h000F);
    repeat (8) @(negedge clk);
    wr(0, 2, 16'h001F);
    rd(0, 0, v);  chk("R5 divider 2 count", v, 16'h0003);
    // R10 load while running beats the advance
    wr(0, 1, 16'h0000);
    wr(0, 2, 16'h000F);
    wr(0, 0, 16'h0100);
    wr(0, 2, 16'h001F);
    rd(0, 0, v);  chk("R10 load priority", v, 16'h0101);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule